// File: doc/BRIEF.md
# Narrow-to-64-bit word packer with end-of-packet flush

This block sits in front of a 64-bit-wide FIFO memory and assembles the narrow words of a write port into full 64-bit memory words. The narrow width is a parameter that divides 64. Narrow words enter through a request/acknowledge handshake: a word moves on every clock in which both `in_req` and `in_ack` are high. Completed 64-bit words leave through a registered valid/ready output that holds its data until the memory side takes it.

Packets of limited length end in two steps. The writer keeps its request high for one clock after its last real word, so one extra narrow word enters the packer. The writer then pulses `flush`. Any partly filled 64-bit word is then sent out with its unused lanes set to zero. At that point the block counts the 64-bit words the packet produced and compares the total against a minimum packet length. A packet that falls short raises `short_pkt`. Once a flush has completed, the block stays closed and accepts nothing until it is reset.

Top module: `pk_packer`

## Requirements
- R1: After the synchronous reset, `out_valid` and `short_pkt` are low, and `in_ack` is high whenever `out_ready` is high.
- R2: Narrow words fill the 64-bit word from the least significant lane upward. The first accepted word of a group occupies bits [IN_W-1:0], and word k occupies bits [k*IN_W +: IN_W].
- R3: When the 64/IN_W-th narrow word of a group is accepted, `out_valid` is high at the following clock edge and carries that group.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays unchanged, and `in_ack` is low.
- R5: A flush that finds a partly filled word sends that word out once, with every lane not yet written set to zero. It waits behind any word already on the output.
- R6: A flush that finds no narrow word pending produces no output word.
- R7: Once a flush has completed, `in_ack` stays low and no further output word appears until reset. A second flush has no effect.
- R8: When a flush completes, `short_pkt` goes high if the packet produced fewer than MIN_WORDS 64-bit words, counting the flushed partial word. Otherwise it stays low.
- R9: The extra narrow word written one clock after the last real word is packed like any other word.
- R10: `in_data` is ignored in any cycle in which `in_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also re-arms the block after a packet |
| in_req | input | 1 | Narrow word offered |
| in_data | input | IN_W | Narrow word |
| in_ack | output | 1 | Narrow word taken when high together with in_req |
| flush | input | 1 | End-of-packet pulse |
| out_valid | output | 1 | 64-bit word available |
| out_data | output | 64 | Packed 64-bit word |
| out_ready | input | 1 | Memory side takes the word this cycle |
| short_pkt | output | 1 | Completed packet was shorter than MIN_WORDS |

## Verification
The assertions assume the following about the inputs:
- Reset is held for at least one clock before traffic starts.
- `in_req`, `flush` and `out_ready` carry known values every cycle; `in_data` only needs to be meaningful while `in_req` is high.
- `flush` arrives no earlier than in the cycle of the last accepted word.

The stimulus drives every input half a clock away from the active edge. It draws request and ready patterns at random, and pulses `flush` only once the packet's words, including the extra one, have been taken. Lengths of 124, 127 and 128 narrow words place packets on both sides of the minimum.

// File: rtl/pk_pack_pkg.sv
package pk_pack_pkg;
  localparam int MEM_W = 64;

  function automatic int lane_bits(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction
endpackage

// File: rtl/pk_lane_acc.sv
module pk_lane_acc #(
  parameter int IN_W   = 16,
  parameter int MEM_W  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IN_W-1:0]  wr_data,
  input  logic             drain,
  output logic [MEM_W-1:0] word_nxt,
  output logic             last_lane,
  output logic             empty
);
  logic [LANE_W-1:0] lane;
  logic [MEM_W-1:0]  acc;

  // one write port per lane, picked by the lane pointer
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_nxt[g*IN_W +: IN_W] =
      (wr_en && lane == LANE_W'(g)) ? wr_data : acc[g*IN_W +: IN_W];
  end

  assign last_lane = (lane == LANE_W'(LANES - 1));
  assign empty     = (lane == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane <= '0;
      acc  <= '0;
    end else if (drain || (wr_en && last_lane)) begin
      lane <= '0;
      acc  <= '0;
    end else if (wr_en) begin
      lane <= lane + 1'b1;
      acc  <= word_nxt;
    end
  end

  assert_lane_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && last_lane |=> empty);
  assert_no_write_on_drain_R5: assert property (@(posedge clk) disable iff (rst)
    !(drain && wr_en));
endmodule

// File: rtl/pk_out_reg.sv
module pk_out_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_load_when_free_R4: assert property (@(posedge clk) disable iff (rst)
    load |-> !out_valid || out_ready);
endmodule

// File: rtl/pk_pkt_ctl.sv
module pk_pkt_ctl #(
  parameter int MIN_WORDS = 32,
  parameter int CNT_W     = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic out_free,
  input  logic acc_empty,
  input  logic load,
  output logic flush_pend,
  output logic flush_go,
  output logic sealed,
  output logic short_pkt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   final_cnt;

  assign flush_go  = flush_pend && out_free;
  assign final_cnt = {1'b0, cnt} + (acc_empty ? (CNT_W+1)'(0) : (CNT_W+1)'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      flush_pend <= 1'b0;
      sealed     <= 1'b0;
      short_pkt  <= 1'b0;
    end else begin
      if (load && cnt < CNT_W'(MIN_WORDS))
        cnt <= cnt + 1'b1;
      if (flush_go) begin
        flush_pend <= 1'b0;
        sealed     <= 1'b1;
        short_pkt  <= (final_cnt < (CNT_W+1)'(MIN_WORDS));
      end else if (flush && !sealed) begin
        flush_pend <= 1'b1;
      end
    end
  end

  assert_seal_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    sealed |=> sealed);
  assert_short_needs_seal_R8: assert property (@(posedge clk) disable iff (rst)
    short_pkt |-> sealed);
  assert_count_capped_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MIN_WORDS));
endmodule

// File: rtl/pk_packer.sv
module pk_packer
  import pk_pack_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int MIN_WORDS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_req,
  input  logic [IN_W-1:0]  in_data,
  output logic             in_ack,
  input  logic             flush,
  output logic             out_valid,
  output logic [MEM_W-1:0] out_data,
  input  logic             out_ready,
  output logic             short_pkt
);
  localparam int LANES  = MEM_W / IN_W;
  localparam int LANE_W = lane_bits(LANES);
  localparam int CNT_W  = $clog2(MIN_WORDS + 1);

  logic             out_free, sealed, flush_pend, flush_go;
  logic             acc_empty, last_lane;
  logic             xfer, full_emit, flush_emit, load;
  logic [MEM_W-1:0] word_nxt;

  assign in_ack     = !sealed && !flush_pend && out_free;
  assign xfer       = in_req && in_ack;
  assign full_emit  = xfer && last_lane;
  assign flush_emit = flush_go && !acc_empty;
  assign load       = full_emit || flush_emit;

  pk_lane_acc #(
    .IN_W(IN_W), .MEM_W(MEM_W), .LANES(LANES), .LANE_W(LANE_W)
  ) i_acc (
    .clk(clk), .rst(rst), .wr_en(xfer), .wr_data(in_data),
    .drain(flush_go), .word_nxt(word_nxt), .last_lane(last_lane),
    .empty(acc_empty)
  );

  pk_out_reg #(.W(MEM_W)) i_out (
    .clk(clk), .rst(rst), .load(load), .load_data(word_nxt),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .free(out_free)
  );

  pk_pkt_ctl #(.MIN_WORDS(MIN_WORDS), .CNT_W(CNT_W)) i_ctl (
    .clk(clk), .rst(rst), .flush(flush), .out_free(out_free),
    .acc_empty(acc_empty), .load(load), .flush_pend(flush_pend),
    .flush_go(flush_go), .sealed(sealed), .short_pkt(short_pkt)
  );

  assert_stall_blocks_ack_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ack);
  assert_quiet_after_seal_R7: assert property (@(posedge clk) disable iff (rst)
    sealed && !out_valid |=> !out_valid);
endmodule

// File: tb/test_pk_packer.sv
module test_pk_packer;
  localparam int IN_W      = 16;
  localparam int MIN_WORDS = 32;
  localparam int LANES     = 64 / IN_W;

  logic clk = 1'b0;
  logic rst, in_req, in_ack, flush, out_valid, out_ready, short_pkt;
  logic [IN_W-1:0] in_data;
  logic [63:0]     out_data;

  always #10 clk = ~clk;

  pk_packer #(.IN_W(IN_W), .MIN_WORDS(MIN_WORDS)) i_pk_packer (
    .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data), .in_ack(in_ack),
    .flush(flush), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .short_pkt(short_pkt)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] expq[$];
  logic [63:0] macc;
  int mlane, mwords, maccepted;
  bit msealed;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    expq.delete();
    macc = '0; mlane = 0; mwords = 0; maccepted = 0; msealed = 0;
  endtask

  // one cycle: drive, then check and update the model
  task automatic step(input bit req, input logic [IN_W-1:0] d, input bit fl,
                      input bit rdy);
    logic ack_exp;
    logic [63:0] e;
    @(negedge clk);
    in_req = req; in_data = d; flush = fl; out_ready = rdy;
    #1;
    ack_exp = !msealed && (!out_valid || out_ready);
    chk(in_ack === ack_exp, "R4/R7 in_ack", 64'(in_ack), 64'(ack_exp));
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(1'b0, "R6 unexpected word", out_data, 64'd0);
      else begin
        e = expq.pop_front();
        chk(out_data === e, "R2 packed word", out_data, e);
      end
    end
    if (req && in_ack) begin
      macc[mlane*IN_W +: IN_W] = d;
      mlane++; maccepted++;
      if (mlane == LANES) begin
        expq.push_back(macc); macc = '0; mlane = 0; mwords++;
      end
    end
    if (fl && !msealed) begin
      if (mlane != 0) begin
        expq.push_back(macc); macc = '0; mlane = 0; mwords++;
      end
      msealed = 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_req = 0; in_data = '0; flush = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_clear();
  endtask

  // n includes the one extra word (R9)
  task automatic send_pkt(input int n);
    while (maccepted < n)
      step(($urandom % 4) != 0, IN_W'($urandom), 0, ($urandom % 4) != 0);
  endtask

  task automatic drain_check();
    repeat (6) step(1, IN_W'($urandom), 0, 1);   // R7: requests ignored
    chk(expq.size() == 0, "R5 all words out", 64'(expq.size()), 64'd0);
    chk(out_valid === 1'b0, "R7 no output after seal", 64'(out_valid), 64'd0);
    chk(short_pkt === (mwords < MIN_WORDS), "R8 short flag", 64'(short_pkt),
        64'(mwords < MIN_WORDS));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    rst = 1; in_req = 0; in_data = '0; flush = 0; out_ready = 1;
    do_reset();
    #1;
    chk(out_valid === 1'b0, "R1 valid after reset", 64'(out_valid), 64'd0);
    chk(short_pkt === 1'b0, "R1 short after reset", 64'(short_pkt), 64'd0);
    chk(in_ack === 1'b1, "R1 ack after reset", 64'(in_ack), 64'd1);

    // R10: data with request low is ignored
    step(0, 16'hdead, 0, 1);
    step(0, 16'hbeef, 0, 1);
    // R2/R3: lane order and timing
    step(1, 16'h0001, 0, 1);
    step(1, 16'h0002, 0, 1);
    step(0, 16'hffff, 0, 1);
    step(1, 16'h0003, 0, 1);
    step(1, 16'h0004, 0, 0);
    step(0, 16'h0000, 0, 0);
    chk(out_valid === 1'b1, "R3 valid after last lane", 64'(out_valid), 64'd1);
    chk(out_data === 64'h0004_0003_0002_0001, "R2 lane order R10",
        out_data, 64'h0004_0003_0002_0001);
    // R4: stall
    for (int i = 0; i < 3; i++) begin
      step(1, 16'h5555, 0, 0);
      chk(out_valid === 1'b1 && out_data === 64'h0004_0003_0002_0001,
          "R4 held word", out_data, 64'h0004_0003_0002_0001);
    end
    step(0, 16'h0, 0, 1);

    // random stream then flush with a partial word
    for (int i = 0; i < 2000; i++)
      step(($urandom % 3) != 0, IN_W'($urandom), 0, ($urandom % 3) != 0);
    while (mlane == 0) step(1, IN_W'($urandom), 0, 1);
    step(0, 0, 1, ($urandom % 2) != 0);
    drain_check();

    // R8 boundary: exactly MIN_WORDS, empty flush (R6)
    do_reset();
    send_pkt(MIN_WORDS * LANES);
    step(0, 0, 1, 1);
    drain_check();

    // R5: padded partial word completes the minimum
    do_reset();
    send_pkt(MIN_WORDS * LANES - 1);
    step(0, 0, 1, 1);
    drain_check();

    // R8: one word short, R6 empty flush
    do_reset();
    send_pkt((MIN_WORDS - 1) * LANES);
    step(0, 0, 1, 1);
    drain_check();

    // R7: second flush has no effect; R9 extra word packed
    do_reset();
    send_pkt(9);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    drain_check();

    // R5: flush while output stalled
    do_reset();
    for (int i = 0; i < LANES; i++) step(1, IN_W'(i + 16'h10), 0, 0);
    step(1, 16'h77, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk(out_valid === 1'b1, "R4 held during pending flush", 64'(out_valid), 64'd1);
    drain_check();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule